// File: doc/BRIEF.md
# Loadable Up/Down Counter with Chain Carry

A small synchronous binary counter that can be cleared, parallel-loaded, held or stepped by one in either direction on each rising clock edge. The action taken at an edge follows a fixed priority: clear, then load, then hold, then step. Stepping needs two enables to be high together. The count wraps in both directions.

A combinational terminal-count output goes high when the count sits at the last value for the selected direction. That value is all ones when counting up and all zeros when counting down. Only one of the two enables gates this output. Feeding one stage's terminal output into the carry-gated enable of the next stage builds a wider counter. In that chain every stage advances on the same clock edge, and the upper stage moves only when all lower stages are about to wrap.

Top module: `updn_counter`

## Requirements
- R1: When `clear_n` is 0 at a rising edge, `q` becomes 0 after that edge, whatever the values of `load_n`, the enables, `dir_up` and `d`.
- R2: When `clear_n` is 1 and `load_n` is 0 at a rising edge, `q` takes the value of `d` after that edge, even if both enables are 1.
- R3: When `clear_n` and `load_n` are both 1, `q` changes by one only if `en_count` and `en_chain` are both 1. Otherwise `q` holds its value.
- R4: A step adds 1 when `dir_up` is 1 and subtracts 1 when `dir_up` is 0, modulo 2^WIDTH. Counting up from all ones gives 0, and counting down from 0 gives all ones.
- R5: `term_out` is combinational. It is 1 exactly when `en_chain` is 1 and `q` is all ones (with `dir_up` = 1) or all zeros (with `dir_up` = 0). It does not depend on `en_count`.
- R6: Two 4-bit instances with shared clear, load and direction make a correct 8-bit counter when connected as follows. The low stage has both enables at 1. The high stage has `en_count` at 1 and `en_chain` driven by the low stage's `term_out`. The high stage loads `d[7:4]`. With this wiring the 8-bit value steps by one modulo 256 in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock; all state changes on its rising edge |
| clear_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_count | input | 1 | Count enable that gates stepping only |
| en_chain | input | 1 | Count enable that gates stepping and the terminal output |
| dir_up | input | 1 | Direction: 1 counts up, 0 counts down |
| d | input | WIDTH | Parallel load value |
| q | output | WIDTH | Current count |
| term_out | output | 1 | Terminal count for the current direction, gated by en_chain |

## Verification
The hardest cases to reach are the wrap boundaries combined with every enable and direction setting. Each such case needs a particular count loaded just before the step. The bench therefore loads every start value and then applies one step under each enable pair and each direction, so every value meets every boundary case. In the cascaded pair, a high-stage move happens only when the low stage wraps. Long runs through all 256 values in each direction, plus loads placed just below and above the wrap points, make the carry cross between stages many times.

// File: rtl/updn_counter_pkg.sv
// Package: shared operation type for the up/down counter.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package updn_counter_pkg;
    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_HOLD  = 2'd2,
        OP_STEP  = 2'd3
    } ctr_op_t;
endpackage

// File: rtl/ctr_op_decode.sv
// Module: resolves clear, load, hold and step into one operation using a
// fixed priority. Assumes active-low clear and load, active-high enables.
module ctr_op_decode
    import updn_counter_pkg::*;
(
    input  logic    clear_n,
    input  logic    load_n,
    input  logic    en_count,
    input  logic    en_chain,
    output ctr_op_t op
);
    // Priority: clear over load over hold over step.
    always_comb begin
        if (!clear_n)                 op = OP_CLEAR;
        else if (!load_n)             op = OP_LOAD;
        else if (en_count && en_chain) op = OP_STEP;
        else                          op = OP_HOLD;
    end
endmodule

// File: rtl/ctr_next_value.sv
// Module: computes the next count from the current count and the resolved
// operation. Assumes the arithmetic wraps modulo 2^WIDTH.
module ctr_next_value
    import updn_counter_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] ld_val,
    input  ctr_op_t          op,
    input  logic             dir_up,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // Select the successor value for the requested operation.
    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = ld_val;
            OP_STEP:  nxt = dir_up ? cur + ONE : cur - ONE;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/ctr_term_detect.sv
// Module: flags the terminal count for the current direction, gated by the
// carry-gating enable. Purely combinational; assumes WIDTH >= 1.
module ctr_term_detect #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             dir_up,
    input  logic             en_chain,
    output logic             term
);
    logic [WIDTH-1:0] bit_at_end;

    // Each bit matches its end value: 1 when counting up, 0 when counting down.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign bit_at_end[i] = (cur[i] == dir_up);
    end

    // All bits at their end value and the carry gate open.
    assign term = en_chain & (&bit_at_end);
endmodule

// File: rtl/updn_counter.sv
// Module: loadable synchronous up/down counter with a chainable terminal
// output. Assumes a single clock; clear_n doubles as the synchronous reset.
module updn_counter
    import updn_counter_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic             load_n,
    input  logic             en_count,
    input  logic             en_chain,
    input  logic             dir_up,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             term_out
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    ctr_op_t          op;
    logic [WIDTH-1:0] q_nxt;

    ctr_op_decode u_decode (
        .clear_n  (clear_n),
        .load_n   (load_n),
        .en_count (en_count),
        .en_chain (en_chain),
        .op       (op)
    );

    ctr_next_value #(.WIDTH(WIDTH)) u_next (
        .cur    (q),
        .ld_val (d),
        .op     (op),
        .dir_up (dir_up),
        .nxt    (q_nxt)
    );

    ctr_term_detect #(.WIDTH(WIDTH)) u_term (
        .cur      (q),
        .dir_up   (dir_up),
        .en_chain (en_chain),
        .term     (term_out)
    );

    // Count register: takes the resolved next value on every rising edge.
    always_ff @(posedge clk) begin
        q <= q_nxt;
    end

    // R1: clear forces zero on the following cycle.
    p_clear_zero_r1: assert property (@(posedge clk)
        !clear_n |=> (q == '0));

    // R2: load captures the parallel input.
    p_load_capture_r2: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n == 1'b0) |=> (q == $past(d)));

    // R3: without both enables the count holds.
    p_hold_r3: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && !(en_count && en_chain)) |=> $stable(q));

    // R4: up step adds one with wrap.
    p_step_up_r4: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && en_count && en_chain && dir_up) |=> (q == $past(q) + 1'b1));

    // R4: down step subtracts one with wrap.
    p_step_down_r4: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && en_count && en_chain && !dir_up) |=> (q == $past(q) - 1'b1));

    // R5: terminal output only with the carry gate open and at the end value.
    p_term_gate_r5: assert property (@(posedge clk) disable iff (!clear_n)
        term_out |-> (en_chain && (dir_up ? (q == ALL_ONES) : (q == '0))));
endmodule

// File: tb/updn_counter_tb.sv
`timescale 1ns/1ps
module updn_counter_tb_top;
    logic       clk = 1'b0;
    logic       clear_n, load_n, en_count, en_chain, dir_up;
    logic [3:0] d;
    logic [3:0] q;
    logic       term_out;

    logic       c_clear_n, c_load_n, c_dir;
    logic [7:0] c_d;
    logic [3:0] lo_q, hi_q;
    logic       lo_t, hi_t;

    int  nvec = 0;
    int  nbad = 0;
    bit  done = 1'b0;
    logic [3:0] mdl;
    logic [7:0] cm;

    always #2.5 clk = ~clk;

    updn_counter #(.WIDTH(4)) dut_i (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .en_count(en_count),
        .en_chain(en_chain), .dir_up(dir_up), .d(d), .q(q), .term_out(term_out)
    );

    updn_counter #(.WIDTH(4)) lo_i (
        .clk(clk), .clear_n(c_clear_n), .load_n(c_load_n), .en_count(1'b1),
        .en_chain(1'b1), .dir_up(c_dir), .d(c_d[3:0]), .q(lo_q), .term_out(lo_t)
    );

    updn_counter #(.WIDTH(4)) hi_i (
        .clk(clk), .clear_n(c_clear_n), .load_n(c_load_n), .en_count(1'b1),
        .en_chain(lo_t), .dir_up(c_dir), .d(c_d[7:4]), .q(hi_q), .term_out(hi_t)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle on the single counter: check term (R5), clock, check q.
    task automatic cyc(input logic c, input logic l, input logic ep,
                       input logic et, input logic u, input logic [3:0] dd);
        string tag;
        logic  exp_t;
        @(negedge clk);
        clear_n = c; load_n = l; en_count = ep; en_chain = et; dir_up = u; d = dd;
        #1;
        exp_t = et && (u ? (mdl == 4'hF) : (mdl == 4'h0));
        check("R5", {7'd0, term_out}, {7'd0, exp_t});
        if (!c) begin mdl = 4'h0; tag = "R1"; end
        else if (!l) begin mdl = dd; tag = "R2"; end
        else if (ep && et) begin
            tag = ((u && mdl == 4'hF) || (!u && mdl == 4'h0)) ? "R4" : "R3";
            mdl = u ? mdl + 4'd1 : mdl - 4'd1;
        end
        else tag = "R3";
        @(posedge clk); #1;
        check(tag, {4'd0, q}, {4'd0, mdl});
    endtask

    // One cycle on the cascaded pair (R6).
    task automatic ccyc(input logic c, input logic l, input logic u, input logic [7:0] dd);
        @(negedge clk);
        c_clear_n = c; c_load_n = l; c_dir = u; c_d = dd;
        if (!c) cm = 8'h00;
        else if (!l) cm = dd;
        else cm = u ? cm + 8'd1 : cm - 8'd1;
        @(posedge clk); #1;
        check("R6", {hi_q, lo_q}, cm);
    endtask

    initial begin
        clear_n = 1'b0; load_n = 1'b0; en_count = 1'b1; en_chain = 1'b1;
        dir_up = 1'b1; d = 4'h9;
        c_clear_n = 1'b0; c_load_n = 1'b0; c_dir = 1'b1; c_d = 8'h5A;
        mdl = 4'h0; cm = 8'h00;
        @(posedge clk); #1;
        check("R1", {4'd0, q}, 8'h00);
        check("R6", {hi_q, lo_q}, 8'h00);

        // Sweep: every start value, direction and enable pair.
        for (int s = 0; s < 16; s++) begin
            for (int u = 0; u < 2; u++) begin
                for (int e = 0; e < 4; e++) begin
                    cyc(1'b1, 1'b0, e[1], e[0], u[0], 4'(s));
                    cyc(1'b1, 1'b1, e[1], e[0], u[0], ~4'(s));
                    cyc(1'b1, 1'b1, e[0], e[1], ~u[0], 4'(s));
                    if (e == 3) cyc(1'b0, 1'b0, 1'b1, 1'b1, u[0], 4'(s));
                end
            end
        end
        // Long free run each way through both wraps.
        for (int k = 0; k < 40; k++) cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'h3);
        for (int k = 0; k < 40; k++) cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'h3);

        // Cascaded 8-bit counter.
        ccyc(1'b0, 1'b1, 1'b1, 8'h00);
        ccyc(1'b1, 1'b0, 1'b1, 8'hF8);
        for (int k = 0; k < 20; k++) ccyc(1'b1, 1'b1, 1'b1, 8'h00);
        ccyc(1'b1, 1'b0, 1'b0, 8'h06);
        for (int k = 0; k < 20; k++) ccyc(1'b1, 1'b1, 1'b0, 8'h00);
        ccyc(1'b1, 1'b0, 1'b0, 8'h10);
        for (int k = 0; k < 300; k++) ccyc(1'b1, 1'b1, 1'b0, 8'h00);
        ccyc(1'b0, 1'b0, 1'b1, 8'hFF);
        for (int k = 0; k < 300; k++) ccyc(1'b1, 1'b1, 1'b1, 8'h00);

        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule